// File: doc/BRIEF.md
# Network Controller Run-Control Register

This block holds the run state of a descriptor-driven network controller. The host issues single-bit commands through one command word: halt, start, initialize and transmit demand. Each command bit takes effect only when written as 1. The block turns these commands into the transmit-enable and receive-enable status flags. It also raises an initialization request towards the DMA engine and a transmit descriptor access request towards the buffer manager. A separate register holds the base address of the initialization block, and that address is always aligned to 4 bytes.

The buffer manager answers with two single-cycle pulses: one when the initialization block has been read, and one when a transmit descriptor has been fetched. Configuration inputs can keep transmit or receive disabled. Another configuration input restricts descriptor polling to explicit demands. A third decides whether a transmit underflow switches transmit off. The periodic poll timer lives outside the block and is seen here only as a one-cycle tick.

Top module: `netctl_runctl`

## Requirements
- R1: After `rst_n` is low at a clock edge, or after a one-cycle `sw_reset` pulse, `cmd_status` reads 0x04 (only the halt bit, bit 2, set). `tx_on`, `rx_on`, `init_req` and `desc_req` are low. A hardware reset also clears `iadr` to 0.
- R2: A command write (`cmd_we` high) with all bits 0 leaves `cmd_status` unchanged. Status layout: bit0 init, bit1 start, bit2 halt, bit3 transmit demand, bit4 transmit on, bit5 receive on, bit6 initialization done, bit7 reads 0.
- R3: A write that sets the halt bit (bit 2) together with start and init leaves `cmd_status` at 0x04.
- R4: Writing halt clears start, init, transmit demand, transmit on, receive on and initialization done on the next edge. It also drops `init_req` and `desc_req`.
- R5: Writing start (bit 1) or init (bit 0) without halt clears the halt bit on the next edge.
- R6: When start and init are written together, `init_req` rises on the next edge. `tx_on` and `rx_on` stay low until an `init_done_in` pulse arrives. That pulse sets initialization done and drops `init_req`, and `tx_on`/`rx_on` rise one edge later. The init bit stays set afterwards.
- R7: A start write with no initialization pending sets `tx_on` two edges after the write if `cfg_tx_dis` is 0. `rx_on` follows the same rule with `cfg_rx_dis`. A flag whose disable input is 1 stays low.
- R8: Writing transmit demand (bit 3) while `tx_on` is high sets the demand bit and `desc_req` on the next edge. A `desc_fetched` pulse clears both. When `tx_on` is low, a demand write leaves the bit at 0 and `desc_req` low.
- R9: With `cfg_demand_only` at 0, a `poll_due` tick while `tx_on` is high raises `desc_req` until `desc_fetched` arrives. With `cfg_demand_only` at 1, `poll_due` has no effect on `desc_req`.
- R10: A `tx_underflow` pulse clears `tx_on` when `cfg_uflo_hold` is 0 and leaves `rx_on` unchanged. When `cfg_uflo_hold` is 1, `tx_on` stays high.
- R11: A write to `iadr` stores every data bit except the two lowest, which always read 0.
- R12: Writing 1 to the read-only positions (bits 4, 5 and 6) changes nothing in `cmd_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_reset | input | 1 | One-cycle synchronous software reset of the command state |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 8 | Command word; 1 bits set commands |
| cmd_status | output | 8 | Command and status readback |
| cfg_tx_dis | input | 1 | Keep transmit disabled |
| cfg_rx_dis | input | 1 | Keep receive disabled |
| cfg_demand_only | input | 1 | Request descriptors only on demand |
| cfg_uflo_hold | input | 1 | Underflow leaves transmit on |
| tx_underflow | input | 1 | Transmit underflow pulse |
| init_req | output | 1 | Request to read the initialization block |
| init_done_in | input | 1 | Initialization block has been read |
| desc_req | output | 1 | Transmit descriptor access request |
| desc_fetched | input | 1 | Transmit descriptor fetched pulse |
| poll_due | input | 1 | Periodic poll tick |
| tx_on | output | 1 | Transmit enabled |
| rx_on | output | 1 | Receive enabled |
| iadr_we | input | 1 | Initialization address write strobe |
| iadr_wdata | input | ADDR_W | Initialization address write data |
| iadr | output | ADDR_W | Aligned initialization block address |

## Verification
The bench builds the block with ADDR_W = 16 and ALIGN_BITS = 2, so the full address width can be driven with all-ones and odd patterns. Those patterns show the forced low bits next to the stored upper bits. The command word has a fixed 8-bit layout, so every combination of halt, start and init written together is in reach. The bench also holds `init_done_in` off for several cycles to show that the enables wait on the handshake rather than on a fixed delay.

// File: rtl/netctl_pkg.sv
// Package: shared bit positions and command type for the run-control block.
// Assumes an 8-bit command/status word; positions are fixed because the
// host software decodes them.
package netctl_pkg;
    localparam int STAT_W  = 8;
    localparam int B_INIT  = 0;
    localparam int B_START = 1;
    localparam int B_STOP  = 2;
    localparam int B_TDMD  = 3;
    localparam int B_TXON  = 4;
    localparam int B_RXON  = 5;
    localparam int B_IDONE = 6;
    localparam int N_CHAN  = 2;
    localparam int CH_TX   = 0;
    localparam int CH_RX   = 1;

    // Decoded write-one-to-set command strobes for a single cycle.
    typedef struct packed {
        logic tdmd;
        logic stop;
        logic start;
        logic init;
    } cmd_wr_t;
endpackage

// File: rtl/netctl_cmd.sv
// Module: netctl_cmd
// Holds the halt, start and init command bits, tracks the initialization
// handshake and issues a one-cycle launch when a start may take effect.
// Assumes wr strobes are already qualified by the write enable and that
// init_done_in is a single-cycle pulse from the buffer manager.
module netctl_cmd
    import netctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sw_reset,
    input  cmd_wr_t wr,
    input  logic    init_done_in,
    output logic    stop_q,
    output logic    start_q,
    output logic    init_q,
    output logic    busy_q,
    output logic    idone_q,
    output logic    launch
);
    logic pend_q;
    logic go_start;
    logic go_init;

    // Halt beats start and init written in the same cycle.
    always_comb begin
        go_start = wr.start & ~wr.stop;
        go_init  = wr.init  & ~wr.stop;
        launch   = pend_q & ~busy_q;
    end

    // Command bits, initialization handshake and pending start.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset) begin
            stop_q  <= 1'b1;
            start_q <= 1'b0;
            init_q  <= 1'b0;
            busy_q  <= 1'b0;
            idone_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (wr.stop) begin
            stop_q  <= 1'b1;
            start_q <= 1'b0;
            init_q  <= 1'b0;
            busy_q  <= 1'b0;
            idone_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (go_start || go_init) stop_q <= 1'b0;
            if (go_start) start_q <= 1'b1;
            if (go_init)  init_q  <= 1'b1;
            if (go_init) begin
                busy_q  <= 1'b1;
                idone_q <= 1'b0;
            end else if (busy_q && init_done_in) begin
                busy_q  <= 1'b0;
                idone_q <= 1'b1;
            end
            if (go_start)    pend_q <= 1'b1;
            else if (launch) pend_q <= 1'b0;
        end
    end

    p_stop_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr.stop |=> (stop_q && !start_q && !init_q));

    p_zero_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr == '0 && !init_done_in && !sw_reset) |=>
            ($stable(stop_q) && $stable(start_q) && $stable(init_q)));

    p_go_clears_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr.start || wr.init) && !wr.stop && !sw_reset) |=> !stop_q);
endmodule

// File: rtl/netctl_onflag.sv
// Module: netctl_onflag
// One enable flag (transmit or receive). Set on a launch unless disabled,
// cleared by halt and, when HAS_UFLO is 1, by an underflow not held off.
// Assumes launch and uflo are single-cycle strobes.
module netctl_onflag #(
    parameter bit HAS_UFLO = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_reset,
    input  logic stop_wr,
    input  logic launch,
    input  logic dis,
    input  logic uflo,
    input  logic uflo_hold,
    output logic on_q
);
    logic uflo_kill;

    // Underflow clear only exists on the variant that has it.
    generate
        if (HAS_UFLO) begin : g_uflo
            assign uflo_kill = uflo & ~uflo_hold;
        end else begin : g_no_uflo
            assign uflo_kill = 1'b0;
        end
    endgenerate

    // Enable flag: halt, then underflow, then launch in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset) on_q <= 1'b0;
        else if (stop_wr)       on_q <= 1'b0;
        else if (uflo_kill)     on_q <= 1'b0;
        else if (launch)        on_q <= ~dis;
    end

    p_uflo_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_UFLO && uflo && !uflo_hold) |=> !on_q);

    p_dis_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && dis) |=> !on_q);
endmodule

// File: rtl/netctl_txdemand.sv
// Module: netctl_txdemand
// Transmit demand bit and poll-pending state; forms the descriptor access
// request. Assumes desc_fetched and poll_due are single-cycle pulses.
module netctl_txdemand (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_reset,
    input  logic stop_wr,
    input  logic txon,
    input  logic tdmd_wr,
    input  logic desc_fetched,
    input  logic poll_due,
    input  logic demand_only,
    output logic tdmd_q,
    output logic desc_req
);
    logic poll_q;

    // Request exists only while transmit is on.
    always_comb begin
        desc_req = txon & (tdmd_q | poll_q);
    end

    // Demand and poll state; both drop while transmit is off.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset || stop_wr || !txon) begin
            tdmd_q <= 1'b0;
            poll_q <= 1'b0;
        end else begin
            tdmd_q <= tdmd_wr | (tdmd_q & ~desc_fetched);
            poll_q <= ~demand_only & (poll_due | (poll_q & ~desc_fetched));
        end
    end

    p_tdmd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_fetched && !tdmd_wr) |=> !tdmd_q);

    p_tdmd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !txon |=> !tdmd_q);

    p_demand_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (demand_only && $past(demand_only) && desc_req) |-> tdmd_q);
endmodule

// File: rtl/netctl_iadr.sv
// Module: netctl_iadr
// Initialization block base address. The lowest ALIGN_BITS bits are
// forced to zero. Assumes 0 < ALIGN_BITS < ADDR_W.
module netctl_iadr #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - ALIGN_BITS;

    logic [HI_W-1:0] hi_q;

    // Stored upper bits of the address.
    always_ff @(posedge clk) begin
        if (!rst_n)  hi_q <= '0;
        else if (we) hi_q <= wdata[ADDR_W-1:ALIGN_BITS];
    end

    // Per-bit output: aligned positions tie to zero.
    generate
        for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
            if (b < ALIGN_BITS) begin : g_zero
                assign addr[b] = 1'b0;
            end else begin : g_reg
                assign addr[b] = hi_q[b-ALIGN_BITS];
            end
        end
    endgenerate

    p_iadr_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (addr[ADDR_W-1:ALIGN_BITS] == $past(wdata[ADDR_W-1:ALIGN_BITS])));
endmodule

// File: rtl/netctl_runctl.sv
// Module: netctl_runctl (top)
// Run-control register of a descriptor-driven network controller: decodes
// the command word, instantiates command, enable, demand and address logic
// and assembles the status readback. Assumes all handshake inputs are
// synchronous single-cycle pulses.
module netctl_runctl
    import netctl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              cmd_we,
    input  logic [STAT_W-1:0] cmd_wdata,
    output logic [STAT_W-1:0] cmd_status,
    input  logic              cfg_tx_dis,
    input  logic              cfg_rx_dis,
    input  logic              cfg_demand_only,
    input  logic              cfg_uflo_hold,
    input  logic              tx_underflow,
    output logic              init_req,
    input  logic              init_done_in,
    output logic              desc_req,
    input  logic              desc_fetched,
    input  logic              poll_due,
    output logic              tx_on,
    output logic              rx_on,
    input  logic              iadr_we,
    input  logic [ADDR_W-1:0] iadr_wdata,
    output logic [ADDR_W-1:0] iadr
);
    cmd_wr_t           wr;
    logic              stop_q, start_q, init_q, busy_q, idone_q, launch;
    logic              tdmd_q;
    logic [N_CHAN-1:0] ch_on;
    logic [N_CHAN-1:0] ch_dis;
    logic [N_CHAN-1:0] ch_uflo;

    // Qualify write-one-to-set strobes; read-only positions are not decoded.
    always_comb begin
        wr.init  = cmd_we & cmd_wdata[B_INIT];
        wr.start = cmd_we & cmd_wdata[B_START];
        wr.stop  = cmd_we & cmd_wdata[B_STOP];
        wr.tdmd  = cmd_we & cmd_wdata[B_TDMD];
    end

    netctl_cmd u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_reset     (sw_reset),
        .wr           (wr),
        .init_done_in (init_done_in),
        .stop_q       (stop_q),
        .start_q      (start_q),
        .init_q       (init_q),
        .busy_q       (busy_q),
        .idone_q      (idone_q),
        .launch       (launch)
    );

    // Per-channel configuration routing.
    always_comb begin
        ch_dis[CH_TX]  = cfg_tx_dis;
        ch_dis[CH_RX]  = cfg_rx_dis;
        ch_uflo[CH_TX] = tx_underflow;
        ch_uflo[CH_RX] = 1'b0;
    end

    generate
        for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
            netctl_onflag #(.HAS_UFLO(c == CH_TX)) u_on (
                .clk       (clk),
                .rst_n     (rst_n),
                .sw_reset  (sw_reset),
                .stop_wr   (wr.stop),
                .launch    (launch),
                .dis       (ch_dis[c]),
                .uflo      (ch_uflo[c]),
                .uflo_hold (cfg_uflo_hold),
                .on_q      (ch_on[c])
            );
        end
    endgenerate

    netctl_txdemand u_tdmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_reset     (sw_reset),
        .stop_wr      (wr.stop),
        .txon         (ch_on[CH_TX]),
        .tdmd_wr      (wr.tdmd),
        .desc_fetched (desc_fetched),
        .poll_due     (poll_due),
        .demand_only  (cfg_demand_only),
        .tdmd_q       (tdmd_q),
        .desc_req     (desc_req)
    );

    netctl_iadr #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_iadr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (iadr_we),
        .wdata (iadr_wdata),
        .addr  (iadr)
    );

    // Status word assembly and handshake outputs.
    always_comb begin
        cmd_status          = '0;
        cmd_status[B_INIT]  = init_q;
        cmd_status[B_START] = start_q;
        cmd_status[B_STOP]  = stop_q;
        cmd_status[B_TDMD]  = tdmd_q;
        cmd_status[B_TXON]  = ch_on[CH_TX];
        cmd_status[B_RXON]  = ch_on[CH_RX];
        cmd_status[B_IDONE] = idone_q;
        tx_on               = ch_on[CH_TX];
        rx_on               = ch_on[CH_RX];
        init_req            = busy_q;
    end

    p_stop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_status[B_STOP] |-> (!tx_on && !rx_on && !init_req && !desc_req));

    p_txon_after_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_on) |-> !$past(init_req));

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (cmd_status == 8'h04));
endmodule

// File: tb/netctl_runctl_tb.sv
`timescale 1ns/1ps
module netctl_runctl_tb_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n, sw_reset, cmd_we;
    logic [7:0]    cmd_wdata, cmd_status;
    logic          cfg_tx_dis, cfg_rx_dis, cfg_demand_only, cfg_uflo_hold;
    logic          tx_underflow, init_req, init_done_in, desc_req;
    logic          desc_fetched, poll_due, tx_on, rx_on, iadr_we;
    logic [AW-1:0] iadr_wdata, iadr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    netctl_runctl #(.ADDR_W(AW), .ALIGN_BITS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .cmd_we(cmd_we),
        .cmd_wdata(cmd_wdata), .cmd_status(cmd_status),
        .cfg_tx_dis(cfg_tx_dis), .cfg_rx_dis(cfg_rx_dis),
        .cfg_demand_only(cfg_demand_only), .cfg_uflo_hold(cfg_uflo_hold),
        .tx_underflow(tx_underflow), .init_req(init_req),
        .init_done_in(init_done_in), .desc_req(desc_req),
        .desc_fetched(desc_fetched), .poll_due(poll_due),
        .tx_on(tx_on), .rx_on(rx_on), .iadr_we(iadr_we),
        .iadr_wdata(iadr_wdata), .iadr(iadr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_cmd(input logic [7:0] d);
        cmd_we = 1'b1; cmd_wdata = d;
        @(negedge clk);
        cmd_we = 1'b0; cmd_wdata = 8'h00;
    endtask

    // Halt then start; returns with both enables on.
    task automatic run_up();
        wr_cmd(8'h04);
        wr_cmd(8'h02);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", cmd_status, 8'h04);
        chk("R1 init_req", init_req, 0);
        chk("R1 desc_req", desc_req, 0);
        chk("R1 iadr", iadr, 0);
    endtask

    task automatic t_zero_and_ro();
        wr_cmd(8'h00);
        chk("R2 zero write", cmd_status, 8'h04);
        wr_cmd(8'h70);
        @(negedge clk);
        chk("R12 ro write", cmd_status, 8'h04);
        chk("R12 tx_on", tx_on, 0);
    endtask

    task automatic t_stop_wins();
        wr_cmd(8'h07);
        chk("R3 status", cmd_status, 8'h04);
        @(negedge clk);
        chk("R3 tx_on", tx_on, 0);
    endtask

    task automatic t_start_only();
        wr_cmd(8'h02);
        chk("R5 halt cleared", cmd_status, 8'h02);
        chk("R7 tx not yet", tx_on, 0);
        @(negedge clk);
        chk("R7 both on", cmd_status, 8'h32);
        wr_cmd(8'h00);
        chk("R2 zero write running", cmd_status, 8'h32);
    endtask

    task automatic t_disable();
        wr_cmd(8'h04);
        cfg_tx_dis = 1'b1;
        wr_cmd(8'h02);
        @(negedge clk);
        chk("R7 tx disabled", tx_on, 0);
        chk("R7 rx on", rx_on, 1);
        wr_cmd(8'h04);
        cfg_tx_dis = 1'b0;
        cfg_rx_dis = 1'b1;
        wr_cmd(8'h02);
        @(negedge clk);
        chk("R7 rx disabled", rx_on, 0);
        chk("R7 tx on", tx_on, 1);
        cfg_rx_dis = 1'b0;
    endtask

    task automatic t_init_start();
        wr_cmd(8'h04);
        wr_cmd(8'h03);
        chk("R6 init_req", init_req, 1);
        chk("R6 status", cmd_status, 8'h03);
        repeat (4) @(negedge clk);
        chk("R6 tx waits", tx_on, 0);
        chk("R6 rx waits", rx_on, 0);
        init_done_in = 1'b1;
        @(negedge clk);
        init_done_in = 1'b0;
        chk("R6 done no req", init_req, 0);
        chk("R6 done status", cmd_status, 8'h43);
        @(negedge clk);
        chk("R6 running, init kept", cmd_status, 8'h73);
    endtask

    task automatic t_tdmd();
        run_up();
        wr_cmd(8'h08);
        chk("R8 tdmd set", cmd_status[3], 1);
        chk("R8 desc_req", desc_req, 1);
        desc_fetched = 1'b1;
        @(negedge clk);
        desc_fetched = 1'b0;
        chk("R8 fetched clears", cmd_status[3], 0);
        chk("R8 desc_req off", desc_req, 0);
        wr_cmd(8'h04);
        wr_cmd(8'h08);
        chk("R8 tx off demand", cmd_status, 8'h04);
        chk("R8 tx off no req", desc_req, 0);
    endtask

    task automatic t_poll();
        run_up();
        cfg_demand_only = 1'b0;
        poll_due = 1'b1;
        @(negedge clk);
        poll_due = 1'b0;
        chk("R9 poll req", desc_req, 1);
        desc_fetched = 1'b1;
        @(negedge clk);
        desc_fetched = 1'b0;
        chk("R9 poll served", desc_req, 0);
        cfg_demand_only = 1'b1;
        @(negedge clk);
        poll_due = 1'b1;
        @(negedge clk);
        poll_due = 1'b0;
        chk("R9 demand only ignores poll", desc_req, 0);
        @(negedge clk);
        chk("R9 still idle", desc_req, 0);
        cfg_demand_only = 1'b0;
    endtask

    task automatic t_uflo();
        run_up();
        cfg_uflo_hold = 1'b0;
        tx_underflow = 1'b1;
        @(negedge clk);
        tx_underflow = 1'b0;
        chk("R10 tx cleared", tx_on, 0);
        chk("R10 rx kept", rx_on, 1);
        run_up();
        cfg_uflo_hold = 1'b1;
        tx_underflow = 1'b1;
        @(negedge clk);
        tx_underflow = 1'b0;
        chk("R10 held", tx_on, 1);
        cfg_uflo_hold = 1'b0;
    endtask

    task automatic t_stop_clears();
        wr_cmd(8'h04);
        wr_cmd(8'h03);
        init_done_in = 1'b1;
        @(negedge clk);
        init_done_in = 1'b0;
        @(negedge clk);
        wr_cmd(8'h08);
        chk("R4 before halt", cmd_status, 8'h7B);
        wr_cmd(8'h04);
        chk("R4 halt clears", cmd_status, 8'h04);
        chk("R4 desc_req", desc_req, 0);
        chk("R4 init_req", init_req, 0);
    endtask

    task automatic t_swreset();
        run_up();
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
        chk("R1 sw reset status", cmd_status, 8'h04);
        chk("R1 sw reset tx", tx_on, 0);
    endtask

    task automatic t_iadr();
        iadr_we = 1'b1; iadr_wdata = 16'hFFFF;
        @(negedge clk);
        iadr_we = 1'b0;
        chk("R11 all ones", iadr, 16'hFFFC);
        iadr_we = 1'b1; iadr_wdata = 16'h1237;
        @(negedge clk);
        iadr_we = 1'b0;
        chk("R11 odd", iadr, 16'h1234);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sw_reset = 1'b0; cmd_we = 1'b0; cmd_wdata = 8'h00;
        cfg_tx_dis = 1'b0; cfg_rx_dis = 1'b0; cfg_demand_only = 1'b0;
        cfg_uflo_hold = 1'b0; tx_underflow = 1'b0; init_done_in = 1'b0;
        desc_fetched = 1'b0; poll_due = 1'b0; iadr_we = 1'b0; iadr_wdata = '0;
        @(negedge clk);
        t_reset();
        t_zero_and_ro();
        t_stop_wins();
        t_start_only();
        t_disable();
        t_init_start();
        t_tdmd();
        t_poll();
        t_uflo();
        t_stop_clears();
        t_swreset();
        t_iadr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule